// File: doc/BRIEF.md
# Single-Precision Result Packer

This block turns an unpacked floating-point value into a 32-bit IEEE-754 binary32 word. The value arrives as a class code, a sign, a signed unbiased exponent, a normalised mantissa and a sticky bit. The mantissa has its leading one in the top bit, and the bits below the 23 fraction bits serve as guard, round and extra sticky. The block sits at the end of an arithmetic datapath, where the last step is to write the result out in single precision.

For numbers it adds the bias, denormalises values that are too small, and rounds in one of four directions. It handles the carry that rounding can push into the exponent, and it saturates values that are too large. Along with the word it reports four flags: underflow, overflow, operand fault and inexact. One conversion is accepted per clock under `in_valid`. The result and its flags appear on registered outputs one cycle later, qualified by `out_valid`.

Top module: `f32_packer`

## Requirements
- R1: A value presented with `in_valid` high at a clock edge appears on `out_word` and the flags after that edge, with `out_valid` high. `out_valid` is low after any edge at which `in_valid` was low. Reset clears `out_valid`, `out_word` and all flags.
- R2: Class code 0 (zero) gives the sign in bit 31 and zeros in bits 30..0. No flag is raised.
- R3: Class code 2 (infinity) gives the sign, exponent field 0xFF and fraction 0. No flag is raised.
- R4: Class code 3 (NaN) gives the sign and exponent field 0xFF. The fraction field is the 23 mantissa bits directly below the leading bit, with fraction bit 22 (the quiet bit) forced to 1 even when the input had it clear. No flag is raised.
- R5: Class code 1 (number) with biased exponent `in_exp + 127` of 1 or more gives that biased exponent in bits 30..23. Bits 22..0 are the 23 mantissa bits below the leading one, rounded.
- R6: `rnd_mode` 0 rounds to nearest, with ties to even. Mode 1 rounds toward zero, mode 2 toward minus infinity and mode 3 toward plus infinity. Bits lost below the 24-bit significand, together with `in_sticky`, decide the rounding. `flag_inexact` is set when any of them is nonzero.
- R7: When rounding a normal value yields a significand of 2.0, the exponent field is incremented and the fraction field is 0.
- R8: A number with a biased exponent of 0 or less sets `flag_under`, whether or not it is exact. It is shifted right by one place plus the magnitude of the biased exponent and then rounded. If it stays subnormal it is written with exponent field 0.
- R9: A subnormal whose rounding carries into bit 23 is written as the smallest normal: exponent field 1 and fraction 0.
- R10: A number whose final exponent is 255 or more sets `flag_over`, `flag_opfault` and `flag_inexact`.
- R11: On overflow the word is infinity in three cases: mode 0, mode 3 with sign 0, and mode 2 with sign 1. In every other case it is the largest finite value, exponent 0xFE with an all-ones fraction. The sign is kept in both cases.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Input value is present this cycle |
| in_class | input | 2 | 0 zero, 1 number, 2 infinity, 3 NaN |
| in_sign | input | 1 | Sign of the value |
| in_exp | input | EXP_W | Unbiased exponent, two's complement |
| in_mant | input | MANT_W | Mantissa with the leading one in the top bit |
| in_sticky | input | 1 | OR of bits already lost below the mantissa |
| rnd_mode | input | 2 | Rounding direction (see R6) |
| out_valid | output | 1 | Registered result is present |
| out_word | output | 32 | Packed binary32 word |
| flag_under | output | 1 | Underflow |
| flag_over | output | 1 | Overflow |
| flag_opfault | output | 1 | Operand fault (raised on overflow) |
| flag_inexact | output | 1 | Result is not exact |

## Verification
The hardest cases to reach are at the subnormal boundary. There, the dynamic shift must move the tie bit exactly to the guard position, so that rounding both promotes the value to the smallest normal and stays on an odd or even last bit. Random exponents almost never land there. The stimulus therefore aims exponents at -127 and nearby with mantissas of all ones and half-way patterns. It also aims at exponents more than a mantissa width below the range, which pushes every bit into the sticky. The same is done at the top of the range, where a carry on rounding alone tips the value into overflow in each mode and for each sign.

// File: rtl/f32_packer_pkg.sv
package f32_packer_pkg;

  typedef enum logic [1:0] {
    CLS_ZERO = 2'd0,
    CLS_NUM  = 2'd1,
    CLS_INF  = 2'd2,
    CLS_NAN  = 2'd3
  } num_class_e;

  typedef enum logic [1:0] {
    RM_NEAREST = 2'd0,
    RM_TOZERO  = 2'd1,
    RM_DOWN    = 2'd2,
    RM_UP      = 2'd3
  } rnd_mode_e;

  localparam int FRAC_W   = 23;
  localparam int SIG_W    = FRAC_W + 1;
  localparam int EFIELD_W = 8;
  localparam int BIAS     = 127;
  localparam int EXP_TOP  = 255;

endpackage

// File: rtl/f32_pk_align.sv
module f32_pk_align #(
  parameter int MANT_W = 32,
  parameter int SH_W   = 6
) (
  input  logic [MANT_W-1:0]                 mant,
  input  logic [SH_W-1:0]                   shift,
  output logic [f32_packer_pkg::SIG_W-1:0]  sig,
  output logic                              guard_bit,
  output logic                              round_bit,
  output logic                              lost_any
);
  import f32_packer_pkg::*;

  localparam int LOW_W = MANT_W - SIG_W - 2;

  logic [MANT_W-1:0] kept;
  logic [MANT_W-1:0] drop_mask;
  logic              dropped_by_shift;
  logic              below_round;

  always_comb begin
    kept             = mant >> shift;
    drop_mask        = ~({MANT_W{1'b1}} << shift);
    dropped_by_shift = |(mant & drop_mask);
  end

  assign sig       = kept[MANT_W-1 -: SIG_W];
  assign guard_bit = kept[MANT_W-SIG_W-1];
  assign round_bit = kept[MANT_W-SIG_W-2];

  generate
    if (LOW_W > 0) begin : g_low
      assign below_round = |kept[LOW_W-1:0];
    end else begin : g_nolow
      assign below_round = 1'b0;
    end
  endgenerate

  assign lost_any = dropped_by_shift | below_round;

endmodule

// File: rtl/f32_pk_round.sv
module f32_pk_round (
  input  logic [1:0] mode,
  input  logic       sign,
  input  logic       lsb,
  input  logic       guard_bit,
  input  logic       round_bit,
  input  logic       sticky,
  output logic       bump,
  output logic       inexact
);
  import f32_packer_pkg::*;

  always_comb begin
    inexact = guard_bit | round_bit | sticky;
    unique case (rnd_mode_e'(mode))
      RM_NEAREST: bump = guard_bit & (round_bit | sticky | lsb);
      RM_TOZERO:  bump = 1'b0;
      RM_DOWN:    bump = sign & inexact;
      RM_UP:      bump = ~sign & inexact;
      default:    bump = 1'b0;
    endcase
  end

endmodule

// File: rtl/f32_packer.sv
module f32_packer #(
  parameter int MANT_W = 32,
  parameter int EXP_W  = 10
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  input  logic [1:0]        in_class,
  input  logic              in_sign,
  input  logic [EXP_W-1:0]  in_exp,
  input  logic [MANT_W-1:0] in_mant,
  input  logic              in_sticky,
  input  logic [1:0]        rnd_mode,
  output logic              out_valid,
  output logic [31:0]       out_word,
  output logic              flag_under,
  output logic              flag_over,
  output logic              flag_opfault,
  output logic              flag_inexact
);
  import f32_packer_pkg::*;

  localparam int BE_W = EXP_W + 2;
  localparam int SH_W = $clog2(MANT_W + 1);

  logic [BE_W-1:0]   biased;
  logic [BE_W-1:0]   sub_amt;
  logic [BE_W-1:0]   exp_norm;
  logic              is_sub;
  logic [SH_W-1:0]   shamt;
  logic [SIG_W-1:0]  sig;
  logic              g_b, r_b, s_b;
  logic              bump, inexact;
  logic [SIG_W:0]    sum;
  logic              ovf, to_inf;
  logic [31:0]       num_word, nxt_word;
  logic [3:0]        nxt_flags;

  // bias and denormalisation shift
  always_comb begin
    biased  = {{2{in_exp[EXP_W-1]}}, in_exp} + BE_W'(BIAS);
    is_sub  = biased[BE_W-1] | (biased == '0);
    sub_amt = BE_W'(1) - biased;
    if (!is_sub)
      shamt = '0;
    else if (sub_amt > BE_W'(MANT_W))
      shamt = SH_W'(MANT_W);
    else
      shamt = sub_amt[SH_W-1:0];
  end

  f32_pk_align #(.MANT_W(MANT_W), .SH_W(SH_W)) u_align (
    .mant      (in_mant),
    .shift     (shamt),
    .sig       (sig),
    .guard_bit (g_b),
    .round_bit (r_b),
    .lost_any  (s_b)
  );

  f32_pk_round u_round (
    .mode      (rnd_mode),
    .sign      (in_sign),
    .lsb       (sig[0]),
    .guard_bit (g_b),
    .round_bit (r_b),
    .sticky    (s_b | in_sticky),
    .bump      (bump),
    .inexact   (inexact)
  );

  // significand increment, exponent carry, saturation
  always_comb begin
    sum      = {1'b0, sig} + {{SIG_W{1'b0}}, bump};
    exp_norm = biased + {{(BE_W-1){1'b0}}, sum[SIG_W]};
    ovf      = !is_sub && (exp_norm >= BE_W'(EXP_TOP));
    unique case (rnd_mode_e'(rnd_mode))
      RM_NEAREST: to_inf = 1'b1;
      RM_TOZERO:  to_inf = 1'b0;
      RM_DOWN:    to_inf = in_sign;
      RM_UP:      to_inf = ~in_sign;
      default:    to_inf = 1'b1;
    endcase
    if (ovf)
      num_word = to_inf ? {in_sign, 8'hFF, 23'h0} : {in_sign, 8'hFE, 23'h7FFFFF};
    else if (is_sub)
      num_word = {in_sign, 7'h00, sum[FRAC_W], sum[FRAC_W-1:0]};
    else if (sum[SIG_W])
      num_word = {in_sign, exp_norm[EFIELD_W-1:0], 23'h0};
    else
      num_word = {in_sign, exp_norm[EFIELD_W-1:0], sum[FRAC_W-1:0]};
  end

  // class selection; flags are {under, over, opfault, inexact}
  always_comb begin
    nxt_flags = 4'b0000;
    unique case (num_class_e'(in_class))
      CLS_ZERO: nxt_word = {in_sign, 31'h0};
      CLS_INF:  nxt_word = {in_sign, 8'hFF, 23'h0};
      CLS_NAN:  nxt_word = {in_sign, 8'hFF, 1'b1, in_mant[MANT_W-3 -: FRAC_W-1]};
      default: begin
        nxt_word  = num_word;
        nxt_flags = {is_sub, ovf, ovf, inexact | ovf};
      end
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid    <= 1'b0;
      out_word     <= '0;
      flag_under   <= 1'b0;
      flag_over    <= 1'b0;
      flag_opfault <= 1'b0;
      flag_inexact <= 1'b0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) begin
        out_word <= nxt_word;
        {flag_under, flag_over, flag_opfault, flag_inexact} <= nxt_flags;
      end
    end
  end

endmodule

// File: rtl/f32_packer_chk.sv
module f32_packer_chk #(
  parameter int MANT_W = 32,
  parameter int EXP_W  = 10
) (
  input logic              clk,
  input logic              rst,
  input logic              in_valid,
  input logic [1:0]        in_class,
  input logic [EXP_W-1:0]  in_exp,
  input logic [MANT_W-1:0] in_mant,
  input logic              out_valid,
  input logic [31:0]       out_word,
  input logic              flag_under,
  input logic              flag_over,
  input logic              flag_opfault,
  input logic              flag_inexact
);

  // R1
  valid_follow_chk: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> out_valid);

  // R1
  valid_drop_chk: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> !out_valid);

  // R2
  zero_word_chk: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_class == 2'd0) |=>
      (out_word[30:0] == 31'h0 && !flag_under && !flag_over && !flag_inexact));

  // R4
  nan_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_class == 2'd3) |=> (out_word[30:22] == 9'h1FF && !flag_opfault));

  // R8
  under_exp_chk: assert property (@(posedge clk) disable iff (rst)
    (out_valid && flag_under) |-> (out_word[30:24] == 7'h00 && !flag_over));

  // R10
  over_flags_chk: assert property (@(posedge clk) disable iff (rst)
    (out_valid && flag_over) |-> (flag_opfault && flag_inexact));

  // R11
  over_word_chk: assert property (@(posedge clk) disable iff (rst)
    (out_valid && flag_over) |->
      (out_word[30:0] == 31'h7F800000 || out_word[30:0] == 31'h7F7FFFFF));

endmodule

bind f32_packer f32_packer_chk #(.MANT_W(MANT_W), .EXP_W(EXP_W)) u_chk (
  .clk          (clk),
  .rst          (rst),
  .in_valid     (in_valid),
  .in_class     (in_class),
  .in_exp       (in_exp),
  .in_mant      (in_mant),
  .out_valid    (out_valid),
  .out_word     (out_word),
  .flag_under   (flag_under),
  .flag_over    (flag_over),
  .flag_opfault (flag_opfault),
  .flag_inexact (flag_inexact)
);

// File: tb/sim_f32_packer.sv
module sim_f32_packer;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        in_valid = 1'b0;
  logic [1:0]  in_class = 2'd0;
  logic        in_sign = 1'b0;
  logic [9:0]  in_exp = '0;
  logic [31:0] in_mant = '0;
  logic        in_sticky = 1'b0;
  logic [1:0]  rnd_mode = 2'd0;
  logic        out_valid;
  logic [31:0] out_word;
  logic        flag_under, flag_over, flag_opfault, flag_inexact;

  int total = 0;
  int bad = 0;
  bit finished = 0;

  logic        pend_valid = 1'b0;
  logic [31:0] pend_word = '0;
  logic [3:0]  pend_flags = '0;
  string       pend_tag = "R1";

  always #4 clk = ~clk;

  f32_packer u0 (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_class(in_class),
    .in_sign(in_sign), .in_exp(in_exp), .in_mant(in_mant),
    .in_sticky(in_sticky), .rnd_mode(rnd_mode), .out_valid(out_valid),
    .out_word(out_word), .flag_under(flag_under), .flag_over(flag_over),
    .flag_opfault(flag_opfault), .flag_inexact(flag_inexact)
  );

  // Behavioural model: remainder comparison on wide integers.
  function automatic void model(input int cls, input bit sgn, input int e,
                                input longint m, input bit stk, input int md,
                                output logic [31:0] w, output logic [3:0] f,
                                output string tag);
    int b, sh, ex;
    longint q, rem, half;
    bit any, up;
    f = 4'b0000;
    if (cls == 0) begin w = {sgn, 31'h0}; tag = "R2"; return; end
    if (cls == 2) begin w = {sgn, 8'hFF, 23'h0}; tag = "R3"; return; end
    if (cls == 3) begin
      w = {sgn, 8'hFF, 1'b1, m[29:8]}; tag = "R4"; return;
    end
    b  = e + 127;
    sh = (b >= 1) ? 8 : 9 - b;
    if (sh >= 40) begin q = 0; rem = m; half = 64'sh40_0000_0000; end
    else begin
      q = m >>> sh; rem = m - (q <<< sh); half = 64'sd1 <<< (sh - 1);
    end
    any = (rem != 0) || stk;
    case (md)
      0: up = (rem > half) || (rem == half && (stk || q[0]));
      1: up = 0;
      2: up = sgn && any;
      default: up = !sgn && any;
    endcase
    q = q + (up ? 1 : 0);
    if (b >= 1) begin
      ex = b; tag = any ? "R6" : "R5";
      if (q == 64'sd16777216) begin ex = b + 1; q = 0; tag = "R7"; end
      if (ex >= 255) begin
        f = 4'b0111; tag = "R11";
        if (md == 0 || (md == 3 && !sgn) || (md == 2 && sgn)) w = {sgn, 8'hFF, 23'h0};
        else w = {sgn, 8'hFE, 23'h7FFFFF};
      end else begin
        w = {sgn, ex[7:0], q[22:0]}; f = {3'b000, any};
      end
    end else begin
      f = {1'b1, 2'b00, any};
      if (q == 64'sd8388608) begin w = {sgn, 8'h01, 23'h0}; tag = "R9"; end
      else begin w = {sgn, 8'h00, q[22:0]}; tag = "R8"; end
    end
  endfunction

  task automatic check_now();
    total++;
    if (out_valid !== pend_valid) begin
      bad++;
      $display("FAIL R1 out_valid actual=%b expected=%b", out_valid, pend_valid);
    end
    if (pend_valid) begin
      total++;
      if (out_word !== pend_word ||
          {flag_under, flag_over, flag_opfault, flag_inexact} !== pend_flags) begin
        bad++;
        $display("FAIL %s word/flags actual=%h/%b expected=%h/%b", pend_tag, out_word,
                 {flag_under, flag_over, flag_opfault, flag_inexact}, pend_word, pend_flags);
      end
    end
  endtask

  task automatic step(input bit v, input int cls, input bit sgn, input int e,
                      input logic [31:0] m, input bit stk, input int md);
    logic [31:0] w;
    logic [3:0]  f;
    string       t;
    @(negedge clk);
    check_now();
    in_valid = v; in_class = cls[1:0]; in_sign = sgn; in_exp = e[9:0];
    in_mant = m; in_sticky = stk; rnd_mode = md[1:0];
    model(cls, sgn, e, {32'h0, m}, stk, md, w, f, t);
    pend_valid = v; pend_word = w; pend_flags = f; pend_tag = t;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R1: reset state
    @(negedge clk);
    total++;
    if (out_valid !== 1'b0 || out_word !== 32'h0 ||
        {flag_under, flag_over, flag_opfault, flag_inexact} !== 4'b0) begin
      bad++;
      $display("FAIL R1 reset actual=%b/%h expected=0/00000000", out_valid, out_word);
    end
    // R2, R3, R4
    step(1, 0, 0, 0, 32'h0, 0, 0);
    step(1, 0, 1, 0, 32'h0, 0, 3);
    step(1, 2, 0, 0, 32'h8000_0000, 0, 0);
    step(1, 2, 1, 0, 32'h8000_0000, 0, 1);
    step(1, 3, 1, 0, 32'h8ABC_DE00, 0, 0);
    step(1, 3, 0, 0, 32'hC000_01FF, 1, 2);
    // R5 exact, R6 ties and directions
    step(1, 1, 0, 0, 32'h8000_0000, 0, 0);
    step(1, 1, 1, 1, 32'hC000_0000, 0, 0);
    step(1, 1, 0, 3, 32'h8000_0080, 0, 0);
    step(1, 1, 0, 3, 32'h8000_0180, 0, 0);
    step(1, 1, 0, 3, 32'h8000_0080, 1, 0);
    for (int md = 0; md < 4; md++) begin
      step(1, 1, 1, -4, 32'h8000_0001, 0, md);
      step(1, 1, 0, -4, 32'h8000_0001, 0, md);
    end
    step(0, 1, 0, 0, 32'h8000_0000, 0, 0);
    // R7 carry
    step(1, 1, 0, 5, 32'hFFFF_FF80, 0, 0);
    step(1, 1, 1, -126, 32'hFFFF_FFFF, 0, 2);
    // R10, R11 overflow each mode and sign
    for (int md = 0; md < 4; md++) begin
      step(1, 1, 0, 127, 32'hFFFF_FFFF, 0, md);
      step(1, 1, 1, 127, 32'hFFFF_FFFF, 0, md);
      step(1, 1, md[0], 128, 32'h8000_0000, 0, md);
    end
    step(1, 1, 0, 127, 32'hFFFF_FF00, 0, 0);
    // R8, R9 subnormals
    step(1, 1, 0, -127, 32'h8000_0000, 0, 0);
    step(1, 1, 1, -130, 32'hA5A5_A5A5, 0, 0);
    step(1, 1, 0, -127, 32'hFFFF_FF00, 0, 0);
    step(1, 1, 0, -127, 32'hFFFF_FE00, 0, 0);
    step(1, 1, 1, -127, 32'hFFFF_FE01, 0, 2);
    step(1, 1, 0, -149, 32'h8000_0000, 0, 0);
    step(1, 1, 0, -150, 32'h8000_0000, 0, 0);
    step(1, 1, 0, -150, 32'h8000_0001, 0, 0);
    step(1, 1, 0, -200, 32'h8000_0000, 0, 3);
    step(1, 1, 0, -200, 32'h8000_0000, 0, 0);
    step(1, 1, 1, -300, 32'hFFFF_FFFF, 1, 2);
    step(1, 1, 0, -126, 32'h8000_0000, 0, 1);
    // mixed random traffic
    for (int i = 0; i < 3000; i++) begin
      int e, cls, pick;
      pick = $urandom_range(0, 9);
      if (pick < 3)      e = $urandom_range(0, 40) - 170;
      else if (pick < 5) e = $urandom_range(0, 12) + 120;
      else               e = $urandom_range(0, 260) - 130;
      cls = ($urandom_range(0, 7) == 0) ? $urandom_range(0, 3) : 1;
      step($urandom_range(0, 3) != 0, cls, $urandom_range(0, 1), e,
           $urandom | 32'h8000_0000, $urandom_range(0, 1), $urandom_range(0, 3));
    end
    step(0, 0, 0, 0, 32'h0, 0, 0);
    @(negedge clk);
    check_now();
    if (!finished) begin
      finished = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    #(8 * 150000);
    if (!finished) begin
      finished = 1;
      total++;
      bad++;
      $display("FAIL watchdog expired");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule